// File: doc/BRIEF.md
# Triple-Node Barrier and Block Sequencer

This controller sits in each of three redundant nodes that run the same work and compare results. After `start` it joins a startup barrier: it keeps sending a fixed sync token to both peers and waits until it has seen that token from each of them. The nodes may enter the barrier at different moments, but they all leave it on the same arrival.

The node then runs an endless chain of synchronized blocks, each lasting a configured number of cycles. Every block opens with a one-cycle start strobe that carries an 8-bit block stamp. The client then computes. When it signals completion, the controller sends a two-byte frame to both peers, the stamp byte first and then the result byte. It collects one such frame from each peer, presents all three values to the voter, and fills the rest of the block with wait cycles.

A peer frame that carries the wrong stamp is not valid for voting. A peer that sends nothing before a timeout is marked absent. A block whose computation does not finish before the period ends is marked as overrun, and the next block begins on schedule anyway.

Top module: `tmr_node_sequencer`

## Requirements
- R1: After reset the node is idle: `tx_valid`, `synced`, `blk_start` and `vote_valid` are all 0.
- R2: While the node is in the barrier, `tx_valid` is 1 and `tx_data` equals the sync token 0xA5 on every cycle.
- R3: The barrier ends only once 0xA5 has arrived on both peer links. A byte with any other value does not count. The first `blk_start` is seen in the cycle after the cycle in which the last missing token arrived.
- R4: Consecutive `blk_start` pulses are exactly `cfg_period` cycles apart. `cfg_period` and `cfg_timeout` are sampled only while the node is idle.
- R5: `blk_stamp` is 0 in the first block and rises by 1 in each later block, wrapping from 255 to 0.
- R6: `compute_done` is sampled at a clock edge. In the cycle after that edge, `tx_valid` is 1 and `tx_data` is the stamp. In the following cycle `tx_data` is the `local_result` that was captured with `compute_done`.
- R7: During the check phase, the first valid byte on a peer link is taken as that peer's stamp and the second as its value. `vote_a_ok`/`vote_b_ok` are 1 only if the peer delivered both bytes and its stamp equals `blk_stamp`. `vote_a`/`vote_b` show the value byte, and `vote_local` shows the captured local result.
- R8: A peer that has not delivered both bytes within `cfg_timeout` cycles of the start of the check phase is reported by `peer_a_absent`/`peer_b_absent` = 1, with its ok flag at 0.
- R9: Each block in which the check phase finishes gives exactly one single-cycle `vote_valid` pulse. The pulse comes when both frames are complete or when the timeout has elapsed, whichever is first.
- R10: If `compute_done` does not arrive before the period ends, that block gives no `vote_valid`. `overrun` then reads 1 from the next `blk_start` until the end of that next block. Otherwise `overrun` reads 0.
- R11: Bytes arriving on a peer link outside the check phase are ignored and do not shift the stamp/value parsing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_period | input | 16 | Block length in cycles (sampled while idle, at least 4) |
| cfg_timeout | input | 16 | Peer frame timeout in cycles from check start (sampled while idle) |
| start | input | 1 | Leave idle and enter the barrier |
| rxa_valid | input | 1 | Byte strobe from peer A |
| rxa_data | input | 8 | Byte from peer A |
| rxb_valid | input | 1 | Byte strobe from peer B |
| rxb_data | input | 8 | Byte from peer B |
| local_result | input | 8 | Local computation result |
| compute_done | input | 1 | Local computation finished |
| tx_valid | output | 1 | Byte strobe toward both peers |
| tx_data | output | 8 | Byte toward both peers |
| synced | output | 1 | Barrier passed; blocks are running |
| blk_start | output | 1 | One-cycle block start strobe |
| blk_stamp | output | 8 | Stamp of the current block |
| overrun | output | 1 | Previous block ended before computation finished |
| vote_valid | output | 1 | Vote inputs valid (one cycle) |
| vote_local | output | 8 | Captured local result |
| vote_a | output | 8 | Value byte from peer A |
| vote_b | output | 8 | Value byte from peer B |
| vote_a_ok | output | 1 | Peer A frame complete with matching stamp |
| vote_b_ok | output | 1 | Peer B frame complete with matching stamp |
| peer_a_absent | output | 1 | Peer A frame incomplete at vote time |
| peer_b_absent | output | 1 | Peer B frame incomplete at vote time |

## Verification
The block loop is driven with a mix of peer behaviours:
- both peers correct;
- one peer sending a stale stamp;
- one peer or both peers silent;
- a stray byte that arrives during computation;
- a computation that never finishes.

These cases separate an invalid frame (ok low, not absent) from a missing one (absent). They also show that early bytes do not misalign the parser, and that an overrun suppresses the vote and is reported in the next block. The barrier is exercised with one peer's token held back and a non-token byte offered in its place. A long run with a short period checks that the stamp wraps and that the spacing of the start strobes stays fixed even though the configuration inputs change after startup.

// File: rtl/tmr_seq_pkg.sv
package tmr_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BARRIER,
    ST_START,
    ST_COMPUTE,
    ST_CHK_STAMP,
    ST_CHK_VAL,
    ST_CHK_WAIT,
    ST_FILL
  } seq_state_e;
endpackage

// File: rtl/tmr_sync_barrier.sv
module tmr_sync_barrier #(
  parameter int unsigned           DW     = 8,
  parameter int unsigned           NPEER  = 2,
  parameter logic [DW-1:0]         TOKEN  = 8'hA5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       en,
  input  logic [NPEER-1:0]           rx_valid,
  input  logic [NPEER-1:0][DW-1:0]   rx_data,
  output logic                       all_seen
);
  logic [NPEER-1:0] got_q;
  logic [NPEER-1:0] hit;

  for (genvar p = 0; p < NPEER; p++) begin : g_peer
    assign hit[p] = rx_valid[p] && (rx_data[p] == TOKEN);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        got_q[p] <= 1'b0;
      end else if (!en) begin
        got_q[p] <= 1'b0;
      end else if (hit[p]) begin
        got_q[p] <= 1'b1;
      end
    end
  end

  assign all_seen = en && (&(got_q | hit));
endmodule

// File: rtl/tmr_frame_rx.sv
module tmr_frame_rx #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          en,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  input  logic [DW-1:0] local_stamp,
  output logic          done,
  output logic          stamp_ok,
  output logic [DW-1:0] value
);
  logic          have_stamp_q;
  logic          done_q;
  logic [DW-1:0] stamp_q;
  logic [DW-1:0] value_q;
  logic          take;

  assign take = en && rx_valid && !done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_stamp_q <= 1'b0;
      done_q       <= 1'b0;
    end else if (clr) begin
      have_stamp_q <= 1'b0;
      done_q       <= 1'b0;
    end else if (take) begin
      have_stamp_q <= 1'b1;
      done_q       <= have_stamp_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stamp_q <= '0;
      value_q <= '0;
    end else begin
      if (take && !have_stamp_q) stamp_q <= rx_data;
      if (take &&  have_stamp_q) value_q <= rx_data;
    end
  end

  assign done     = done_q;
  assign stamp_ok = done_q && (stamp_q == local_stamp);
  assign value    = value_q;
endmodule

// File: rtl/tmr_block_timer.sv
module tmr_block_timer #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] period,
  input  logic [CW-1:0] timeout,
  input  logic          blk_begin,
  input  logic          in_block,
  input  logic          in_check,
  output logic          period_end,
  output logic          chk_timeout
);
  logic [CW-1:0] pcnt_q;
  logic [CW-1:0] ccnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt_q <= '0;
    end else if (blk_begin) begin
      pcnt_q <= CW'(1);
    end else if (in_block) begin
      pcnt_q <= pcnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ccnt_q <= '0;
    end else if (!in_check) begin
      ccnt_q <= '0;
    end else if (ccnt_q != '1) begin
      ccnt_q <= ccnt_q + CW'(1);
    end
  end

  assign period_end  = in_block && (pcnt_q == period - CW'(1));
  assign chk_timeout = in_check && (ccnt_q >= timeout);
endmodule

// File: rtl/tmr_node_sequencer.sv
module tmr_node_sequencer #(
  parameter int unsigned   DW         = 8,
  parameter int unsigned   CW         = 16,
  parameter logic [DW-1:0] SYNC_TOKEN = 8'hA5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cfg_period,
  input  logic [CW-1:0] cfg_timeout,
  input  logic          start,
  input  logic          rxa_valid,
  input  logic [DW-1:0] rxa_data,
  input  logic          rxb_valid,
  input  logic [DW-1:0] rxb_data,
  input  logic [DW-1:0] local_result,
  input  logic          compute_done,
  output logic          tx_valid,
  output logic [DW-1:0] tx_data,
  output logic          synced,
  output logic          blk_start,
  output logic [DW-1:0] blk_stamp,
  output logic          overrun,
  output logic          vote_valid,
  output logic [DW-1:0] vote_local,
  output logic [DW-1:0] vote_a,
  output logic [DW-1:0] vote_b,
  output logic          vote_a_ok,
  output logic          vote_b_ok,
  output logic          peer_a_absent,
  output logic          peer_b_absent
);
  import tmr_seq_pkg::*;

  localparam int unsigned NPEER = 2;

  seq_state_e state_q, state_d;

  logic [CW-1:0] period_q;
  logic [CW-1:0] timeout_q;
  logic [DW-1:0] stamp_q;
  logic [DW-1:0] result_q;
  logic          overrun_q;
  logic          vote_q;
  logic [NPEER-1:0] ok_q;
  logic [NPEER-1:0] absent_q;

  logic cfg_load, in_barrier, in_block, in_check, blk_begin;
  logic period_end, chk_timeout, all_seen, vote_fire, rx_clr;

  logic [NPEER-1:0]         rx_valid;
  logic [NPEER-1:0][DW-1:0] rx_data;
  logic [NPEER-1:0]         rx_done;
  logic [NPEER-1:0]         rx_ok;
  logic [NPEER-1:0][DW-1:0] rx_value;

  assign rx_valid = {rxb_valid, rxa_valid};
  assign rx_data  = {rxb_data,  rxa_data};

  assign cfg_load   = (state_q == ST_IDLE);
  assign in_barrier = (state_q == ST_BARRIER);
  assign blk_begin  = (state_q == ST_START);
  assign in_check   = (state_q == ST_CHK_STAMP) || (state_q == ST_CHK_VAL) ||
                      (state_q == ST_CHK_WAIT);
  assign in_block   = in_check || (state_q == ST_COMPUTE) || (state_q == ST_FILL);
  assign rx_clr     = !in_block;
  assign vote_fire  = (state_q == ST_CHK_WAIT) && !period_end &&
                      ((&rx_done) || chk_timeout);

  tmr_sync_barrier #(
    .DW(DW), .NPEER(NPEER), .TOKEN(SYNC_TOKEN)
  ) u_barrier (
    .clk(clk), .rst_n(rst_n), .en(in_barrier),
    .rx_valid(rx_valid), .rx_data(rx_data), .all_seen(all_seen)
  );

  tmr_block_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .period(period_q), .timeout(timeout_q),
    .blk_begin(blk_begin), .in_block(in_block), .in_check(in_check),
    .period_end(period_end), .chk_timeout(chk_timeout)
  );

  for (genvar p = 0; p < NPEER; p++) begin : g_rx
    tmr_frame_rx #(.DW(DW)) u_rx (
      .clk(clk), .rst_n(rst_n), .clr(rx_clr), .en(in_check),
      .rx_valid(rx_valid[p]), .rx_data(rx_data[p]), .local_stamp(stamp_q),
      .done(rx_done[p]), .stamp_ok(rx_ok[p]), .value(rx_value[p])
    );
  end

  // next-state logic
  always_comb begin
    state_d = state_q;
    if (period_end) begin
      state_d = ST_START;
    end else begin
      unique case (state_q)
        ST_IDLE:      if (start) state_d = ST_BARRIER;
        ST_BARRIER:   if (all_seen) state_d = ST_START;
        ST_START:     state_d = ST_COMPUTE;
        ST_COMPUTE:   if (compute_done) state_d = ST_CHK_STAMP;
        ST_CHK_STAMP: state_d = ST_CHK_VAL;
        ST_CHK_VAL:   state_d = ST_CHK_WAIT;
        ST_CHK_WAIT:  if (vote_fire) state_d = ST_FILL;
        ST_FILL:      state_d = ST_FILL;
        default:      state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  // configuration, sampled only while idle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_q  <= '0;
      timeout_q <= '0;
    end else if (cfg_load) begin
      period_q  <= cfg_period;
      timeout_q <= cfg_timeout;
    end
  end

  // block stamp
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stamp_q <= '0;
    end else if (cfg_load) begin
      stamp_q <= '0;
    end else if (period_end) begin
      stamp_q <= stamp_q + DW'(1);
    end
  end

  // local result capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_q <= '0;
    end else if ((state_q == ST_COMPUTE) && compute_done && !period_end) begin
      result_q <= local_result;
    end
  end

  // overrun flag, refreshed at every period end
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      overrun_q <= 1'b0;
    end else if (period_end) begin
      overrun_q <= (state_q != ST_FILL);
    end
  end

  // vote strobe and per-peer verdicts
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vote_q   <= 1'b0;
      ok_q     <= '0;
      absent_q <= '0;
    end else begin
      vote_q <= vote_fire;
      if (vote_fire) begin
        ok_q     <= rx_ok;
        absent_q <= ~rx_done;
      end
    end
  end

  always_comb begin
    tx_valid = 1'b0;
    tx_data  = '0;
    unique case (state_q)
      ST_BARRIER:   begin tx_valid = 1'b1; tx_data = SYNC_TOKEN; end
      ST_CHK_STAMP: begin tx_valid = 1'b1; tx_data = stamp_q;    end
      ST_CHK_VAL:   begin tx_valid = 1'b1; tx_data = result_q;   end
      default:      ;
    endcase
  end

  assign synced        = !cfg_load && !in_barrier;
  assign blk_start     = blk_begin;
  assign blk_stamp     = stamp_q;
  assign overrun       = overrun_q;
  assign vote_valid    = vote_q;
  assign vote_local    = result_q;
  assign vote_a        = rx_value[0];
  assign vote_b        = rx_value[1];
  assign vote_a_ok     = ok_q[0];
  assign vote_b_ok     = ok_q[1];
  assign peer_a_absent = absent_q[0];
  assign peer_b_absent = absent_q[1];
endmodule

// File: rtl/tmr_node_sequencer_chk.sv
module tmr_node_sequencer_chk #(
  parameter int unsigned   DW    = 8,
  parameter int unsigned   CW    = 16,
  parameter logic [DW-1:0] TOKEN = 8'hA5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          synced,
  input logic          blk_start,
  input logic [DW-1:0] blk_stamp,
  input logic          tx_valid,
  input logic [DW-1:0] tx_data,
  input logic          vote_valid,
  input logic          vote_a_ok,
  input logic          vote_b_ok,
  input logic          peer_a_absent,
  input logic          peer_b_absent,
  input logic [CW-1:0] period_q
);
  logic [CW-1:0] since_q;
  logic          seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_q <= '0;
      seen_q  <= 1'b0;
    end else begin
      since_q <= blk_start ? CW'(1) : since_q + CW'(1);
      seen_q  <= seen_q || blk_start;
    end
  end

  p_token_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !synced) |-> (tx_data == TOKEN));

  p_period_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_start && seen_q) |-> (since_q == period_q));

  p_stamp_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_start && $past(synced)) |-> (blk_stamp == $past(blk_stamp) + DW'(1)));

  p_frame_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (synced && tx_valid && $past(synced && tx_valid)) |=> !tx_valid);

  p_absent_a_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (vote_valid && peer_a_absent) |-> !vote_a_ok);

  p_absent_b_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (vote_valid && peer_b_absent) |-> !vote_b_ok);

  p_single_vote_r9: assert property (@(posedge clk) disable iff (!rst_n)
    vote_valid |=> !vote_valid);

  p_vote_in_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
    vote_valid |-> (synced && !blk_start));
endmodule

bind tmr_node_sequencer tmr_node_sequencer_chk #(
  .DW(DW), .CW(CW), .TOKEN(SYNC_TOKEN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .synced(synced), .blk_start(blk_start),
  .blk_stamp(blk_stamp), .tx_valid(tx_valid), .tx_data(tx_data),
  .vote_valid(vote_valid), .vote_a_ok(vote_a_ok), .vote_b_ok(vote_b_ok),
  .peer_a_absent(peer_a_absent), .peer_b_absent(peer_b_absent),
  .period_q(period_q)
);

// File: tb/test_tmr_node_sequencer.sv
`timescale 1ns/1ps
module test_tmr_node_sequencer;
  localparam logic [7:0] TOK    = 8'hA5;
  localparam int         PERIOD = 40;
  localparam int         TMO    = 6;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cfg_period, cfg_timeout;
  logic        start;
  logic        rxa_valid, rxb_valid;
  logic [7:0]  rxa_data, rxb_data;
  logic [7:0]  local_result;
  logic        compute_done;
  logic        tx_valid, synced, blk_start, overrun, vote_valid;
  logic [7:0]  tx_data, blk_stamp, vote_local, vote_a, vote_b;
  logic        vote_a_ok, vote_b_ok, peer_a_absent, peer_b_absent;

  always #5 clk = ~clk;

  tmr_node_sequencer i_tmr_node_sequencer (
    .clk(clk), .rst_n(rst_n), .cfg_period(cfg_period), .cfg_timeout(cfg_timeout),
    .start(start), .rxa_valid(rxa_valid), .rxa_data(rxa_data),
    .rxb_valid(rxb_valid), .rxb_data(rxb_data), .local_result(local_result),
    .compute_done(compute_done), .tx_valid(tx_valid), .tx_data(tx_data),
    .synced(synced), .blk_start(blk_start), .blk_stamp(blk_stamp),
    .overrun(overrun), .vote_valid(vote_valid), .vote_local(vote_local),
    .vote_a(vote_a), .vote_b(vote_b), .vote_a_ok(vote_a_ok), .vote_b_ok(vote_b_ok),
    .peer_a_absent(peer_a_absent), .peer_b_absent(peer_b_absent)
  );

  typedef struct packed {
    logic [7:0] cd;      // compute delay, 255 = never finishes
    logic [7:0] res;
    logic       a_send, a_bad;
    logic [7:0] aval;
    logic       b_send, b_bad;
    logic [7:0] bval;
    logic       early;
    logic       ea_ok, ea_abs, eb_ok, eb_abs;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t TBL [NV] = '{
    '{8'd3,   8'h11, 1'b1, 1'b0, 8'h11, 1'b1, 1'b0, 8'h11, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},
    '{8'd5,   8'h22, 1'b1, 1'b0, 8'h22, 1'b1, 1'b1, 8'h99, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    '{8'd2,   8'h33, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 8'h33, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
    '{8'd255, 8'h44, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{8'd4,   8'h55, 1'b1, 1'b0, 8'h56, 1'b1, 1'b0, 8'h57, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
    '{8'd1,   8'h66, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
    '{8'd6,   8'h77, 1'b1, 1'b1, 8'h70, 1'b1, 1'b0, 8'h77, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
    '{8'd3,   8'h88, 1'b1, 1'b0, 8'h88, 1'b1, 1'b0, 8'h88, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0}
  };

  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;
  int last_start;
  bit finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_start();
    for (int k = 0; k < 2000; k++) begin
      @(negedge clk);
      if (blk_start) return;
    end
    chk(1'b0, "R4 start timeout", 0, 1);
  endtask

  task automatic do_reset(input int per);
    rst_n = 1'b0; start = 1'b0; compute_done = 1'b0; local_result = 8'h00;
    rxa_valid = 1'b0; rxb_valid = 1'b0; rxa_data = 8'h00; rxb_data = 8'h00;
    cfg_period = 16'(per); cfg_timeout = 16'(TMO);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int stamp_exp;
    bit at_start;
    bit got;

    // ---------------- reset state: R1 ----------------
    do_reset(PERIOD);
    for (int k = 0; k < 3; k++) begin
      chk(!tx_valid && !synced && !blk_start && !vote_valid, "R1 idle outputs", tx_valid, 0);
      @(negedge clk);
    end

    // ---------------- barrier: R2, R3 ----------------
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(tx_valid && tx_data == TOK, "R2 token sent", tx_data, TOK);
    rxb_valid = 1'b1; rxb_data = TOK;
    @(negedge clk);
    rxb_valid = 1'b0;
    rxa_valid = 1'b1; rxa_data = 8'h5A;   // not the token
    @(negedge clk);
    rxa_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(!synced && !blk_start, "R3 one peer plus non-token byte not enough", synced, 0);
    chk(tx_valid && tx_data == TOK, "R2 token re-sent", tx_data, TOK);
    rxa_valid = 1'b1; rxa_data = TOK;
    @(negedge clk);
    rxa_valid = 1'b0;
    chk(blk_start && synced, "R3 start one cycle after last token", blk_start, 1);
    last_start = cyc;
    cfg_period = 16'd99;                   // must not take effect: R4
    cfg_timeout = 16'd1;

    // ---------------- table of blocks ----------------
    stamp_exp = 0;
    at_start = 1'b1;
    for (int i = 0; i < NV; i++) begin
      if (!at_start) begin
        wait_start();
        chk(cyc - last_start == PERIOD, "R4 period spacing", cyc - last_start, PERIOD);
        last_start = cyc;
      end
      at_start = 1'b0;
      chk(blk_stamp == 8'(stamp_exp), "R5 stamp", blk_stamp, stamp_exp);
      if (i > 0)
        chk(overrun == (TBL[i-1].cd == 8'd255), "R10 overrun flag", overrun,
            (TBL[i-1].cd == 8'd255));
      else
        chk(!overrun, "R10 overrun clear", overrun, 0);

      if (TBL[i].early) begin
        @(negedge clk);
        rxa_valid = 1'b1; rxa_data = 8'hC3;   // outside the check phase: R11
        @(negedge clk);
        rxa_valid = 1'b0;
      end

      if (TBL[i].cd == 8'd255) begin
        got = 1'b0;
        for (int k = 0; k < 2000; k++) begin
          @(negedge clk);
          if (vote_valid) got = 1'b1;
          if (blk_start) break;
        end
        chk(!got, "R10 no vote on overrun", got, 0);
        chk(cyc - last_start == PERIOD, "R4 period after overrun", cyc - last_start, PERIOD);
        last_start = cyc;
        at_start = 1'b1;
      end else begin
        repeat (int'(TBL[i].cd)) @(negedge clk);
        compute_done = 1'b1; local_result = TBL[i].res;
        @(negedge clk);
        compute_done = 1'b0; local_result = 8'hEE;
        chk(tx_valid && tx_data == 8'(stamp_exp), "R6 stamp byte", tx_data, stamp_exp);
        @(negedge clk);
        chk(tx_valid && tx_data == TBL[i].res, "R6 value byte", tx_data, TBL[i].res);
        rxa_valid = TBL[i].a_send; rxa_data = 8'(stamp_exp + int'(TBL[i].a_bad));
        rxb_valid = TBL[i].b_send; rxb_data = 8'(stamp_exp + int'(TBL[i].b_bad));
        @(negedge clk);
        rxa_data = TBL[i].aval; rxb_data = TBL[i].bval;
        @(negedge clk);
        rxa_valid = 1'b0; rxb_valid = 1'b0;
        got = 1'b0;
        for (int k = 0; k < 30; k++) begin
          if (vote_valid) begin got = 1'b1; break; end
          @(negedge clk);
        end
        chk(got, "R9 vote pulse", got, 1);
        if (got) begin
          chk(vote_local == TBL[i].res, "R7 local value", vote_local, TBL[i].res);
          chk(vote_a_ok == TBL[i].ea_ok, "R7 peer A ok", vote_a_ok, TBL[i].ea_ok);
          chk(vote_b_ok == TBL[i].eb_ok, "R7 peer B ok", vote_b_ok, TBL[i].eb_ok);
          chk(peer_a_absent == TBL[i].ea_abs, "R8 peer A absent", peer_a_absent, TBL[i].ea_abs);
          chk(peer_b_absent == TBL[i].eb_abs, "R8 peer B absent", peer_b_absent, TBL[i].eb_abs);
          if (TBL[i].a_send)
            chk(vote_a == TBL[i].aval, "R11 R7 peer A value", vote_a, TBL[i].aval);
          if (TBL[i].b_send)
            chk(vote_b == TBL[i].bval, "R7 peer B value", vote_b, TBL[i].bval);
          @(negedge clk);
          chk(!vote_valid, "R9 single pulse", vote_valid, 0);
        end
      end
      stamp_exp = (stamp_exp + 1) % 256;
    end

    // ---------------- stamp wrap with short period: R5, R4 ----------------
    do_reset(4);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    rxa_valid = 1'b1; rxa_data = TOK; rxb_valid = 1'b1; rxb_data = TOK;
    @(negedge clk);
    rxa_valid = 1'b0; rxb_valid = 1'b0;
    chk(blk_start && blk_stamp == 8'd0, "R5 first stamp zero", blk_stamp, 0);
    last_start = cyc;
    for (int b = 1; b <= 257; b++) begin
      wait_start();
      if (b == 1 || b == 256)
        chk(cyc - last_start == 4, "R4 short period", cyc - last_start, 4);
      last_start = cyc;
      if (b == 255) chk(blk_stamp == 8'd255, "R5 stamp 255", blk_stamp, 255);
      if (b == 256) chk(blk_stamp == 8'd0, "R5 stamp wrap", blk_stamp, 0);
      if (b == 257) chk(blk_stamp == 8'd1 && overrun, "R10 R5 after wrap", blk_stamp, 1);
    end

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule